// File: doc/BRIEF.md
# DRAM Refresh Sequencer with Stretchable RAS

This block creates refresh cycles for a DRAM controller. A free-running timer, built from the system clock, produces a 2 MHz tick and from it one internal refresh request about every 15 µs. The request stays pending until the sequencer serves it. A refresh drives the RAS strobes low for a programmed number of clocks, then holds off for a programmed precharge time. At the end of each refresh a row counter steps to the next row, and the counter's value is output as the refresh row address.

Two control inputs let the surrounding controller steer refresh. A request input held while the inhibit input is low clears the row counter. If it is held for a whole 2 MHz tick, it also restarts the request timer. When the request input is held together with the inhibit input, back-to-back refreshes run, separated by the precharge time, for as long as the request input stays high. The inhibit input alone holds off internal refreshes. In all-bank mode a stretch input keeps the strobes low for extra clocks. In single-bank mode only one strobe falls and the stretch input is ignored.

Top module: `refresh_seq`

## Requirements
- R1: After synchronous reset, all `ras_n_o` bits are high (inactive), `active_o` is 0, `row_o` is 0 and no internal request is pending.
- R2: With `bank_mode_i`=0, a refresh drives every `ras_n_o` bit low for N clocks, where N = `ras_cycles_i` and the value 0 counts as 1. The strobes fall one clock after the edge that starts the refresh.
- R3: With `bank_mode_i`=0, `stretch_i` is ignored at the first N-1 edges after the start. From the Nth edge on, each edge that samples it high keeps the strobes low one clock longer, and the first edge that samples it low ends the refresh. If it is held high for the first K strobe-low clocks, the strobes stay low for max(N, K+1) clocks when K is at least N, and N clocks otherwise.
- R4: With `bank_mode_i`=1, only bit (`row_o` mod NUM_RAS) of `ras_n_o` goes low, for exactly N clocks, and `stretch_i` has no effect.
- R5: After the strobes rise, `active_o` stays high for P more clocks, where P = `pre_cycles_i` and the value 0 counts as 1. No strobe falls again within those P clocks.
- R6: `row_o` steps by one at the end of every refresh and wraps from ROWS-1 to 0.
- R7: A clock edge that samples `refresh_req_i`=1 and `refresh_inhibit_i`=0 clears `row_o` to 0. No internal refresh starts at such an edge.
- R8: While `refresh_req_i` and `refresh_inhibit_i` are both held high, refreshes run back to back, with exactly P strobe-high clocks between them. The refresh in progress when `refresh_req_i` drops still completes, and no further refresh follows it.
- R9: Internal requests come every PERIOD = (CLK_HZ/2,000,000)×30 clocks. A request that arrives while `refresh_inhibit_i` is high is held, and its refresh starts at the first edge that samples the inhibit input low, so the strobes fall one clock after that edge.
- R10: Holding `refresh_req_i`=1 with `refresh_inhibit_i`=0 for at least CLK_HZ/2,000,000 consecutive clocks restarts the request timer and drops any pending request. The first internal refresh then starts at the edge PERIOD clocks after the first edge that samples the request input low. A shorter hold does not disturb the timer.
- R11: `active_o` is high whenever any strobe is low, and from the first strobe fall of a refresh until its precharge ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| refresh_req_i | input | 1 | External refresh request |
| refresh_inhibit_i | input | 1 | Holds off internal refresh; with the request input, runs burst refresh |
| stretch_i | input | 1 | Extends an all-bank refresh while sampled high |
| bank_mode_i | input | 1 | 0: all strobes, 1: one strobe chosen by row low bits |
| ras_cycles_i | input | CW | Strobe-low clocks per refresh |
| pre_cycles_i | input | CW | Precharge clocks after each refresh |
| ras_n_o | output | NUM_RAS | Active-low row strobes |
| row_o | output | AW | Refresh row address |
| active_o | output | 1 | Refresh in progress |

## Verification
The assertions take for granted that `ras_cycles_i`, `pre_cycles_i` and `bank_mode_i` do not change while a refresh is running. They also assume `stretch_i` is a clean synchronous level. The stimulus changes the programmed counts and the mode only on the falling edge, in the same half-cycle that raises the request, so the values are stable before the edge that latches them. The stretch input is driven only while a refresh is running. The bench also times the internal request stream. It moves the timer-clear holds and the short holds away from the moments when a request would fall due, so every expected latency is exact.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RAS  = 2'd1,
    ST_PRE  = 2'd2
  } rfs_state_t;
endpackage

// File: rtl/rfs_timer.sv
module rfs_timer #(
  parameter int TICK_DIV  = 50,
  parameter int REQ_TICKS = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_i,
  output logic req_o,
  output logic clr_o
);
  localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int RW = (REQ_TICKS > 1) ? $clog2(REQ_TICKS) : 1;
  localparam logic [TW-1:0] TICK_MAX = TW'(TICK_DIV - 1);
  localparam logic [RW-1:0] REQ_MAX  = RW'(REQ_TICKS - 1);

  logic [TW-1:0] tick_q, hold_q;
  logic [RW-1:0] reqc_q;
  logic          tick;

  assign tick  = (tick_q == TICK_MAX);
  assign clr_o = hold_i && (hold_q == TICK_MAX);
  assign req_o = tick && (reqc_q == REQ_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= '0;
      hold_q <= '0;
      reqc_q <= '0;
    end else begin
      if (!hold_i)                hold_q <= '0;
      else if (hold_q != TICK_MAX) hold_q <= hold_q + 1'b1;
      if (clr_o) begin
        tick_q <= '0;
        reqc_q <= '0;
      end else begin
        tick_q <= tick ? '0 : tick_q + 1'b1;
        if (tick) reqc_q <= (reqc_q == REQ_MAX) ? '0 : reqc_q + 1'b1;
      end
    end
  end

  AST_QUIET_AFTER_CLR: assert property (@(posedge clk) disable iff (rst)
    clr_o |=> !req_o); // R10
endmodule

// File: rtl/rfs_row_ctr.sv
module rfs_row_ctr #(
  parameter int ROWS = 512,
  parameter int AW   = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [AW-1:0] row_o
);
  localparam logic [AW-1:0] LAST = AW'(ROWS - 1);

  logic [AW-1:0] row_q;
  assign row_o = row_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)  row_q <= '0;
    else if (inc_i)    row_q <= (row_q == LAST) ? '0 : row_q + 1'b1;
  end

  AST_ROW_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (row_q == '0)); // R7
  AST_ROW_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && inc_i && row_q == LAST) |=> (row_q == '0)); // R6
endmodule

// File: rtl/rfs_fsm.sv
module rfs_fsm
  import refresh_pkg::*;
#(
  parameter int NUM_RAS = 4,
  parameter int CW      = 4,
  parameter int BW      = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               int_req_i,
  input  logic               timer_clr_i,
  input  logic               refresh_req_i,
  input  logic               refresh_inhibit_i,
  input  logic               stretch_i,
  input  logic               bank_mode_i,
  input  logic [CW-1:0]      ras_cycles_i,
  input  logic [CW-1:0]      pre_cycles_i,
  input  logic [BW-1:0]      bank_i,
  output logic [NUM_RAS-1:0] ras_n_o,
  output logic               active_o,
  output logic               done_o
);
  rfs_state_t         st_q, st_d;
  logic [CW-1:0]      cnt_q, cnt_d, n_q, p_q;
  logic               mode_q, pend_q, start;
  logic [NUM_RAS-1:0] mask_q, mask_d;
  logic               int_go, ext_go, go;
  logic [CW-1:0]      n_in, p_in;

  assign int_go = pend_q && !refresh_inhibit_i && !refresh_req_i;
  assign ext_go = refresh_req_i && refresh_inhibit_i;
  assign go     = int_go || ext_go;
  assign n_in   = (ras_cycles_i == '0) ? CW'(1) : ras_cycles_i;
  assign p_in   = (pre_cycles_i == '0) ? CW'(1) : pre_cycles_i;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    start  = 1'b0;
    done_o = 1'b0;
    mask_d = mask_q;
    unique case (st_q)
      ST_IDLE: if (go) start = 1'b1;
      ST_RAS: begin
        if (cnt_q >= n_q) begin
          if (!(stretch_i && !mode_q)) begin
            st_d   = ST_PRE;
            cnt_d  = CW'(1);
            done_o = 1'b1;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_PRE: begin
        if (cnt_q >= p_q) begin
          if (go) start = 1'b1;
          else    st_d  = ST_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (start) begin
      st_d   = ST_RAS;
      cnt_d  = CW'(1);
      mask_d = bank_mode_i ? (NUM_RAS'(1) << bank_i) : '1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      n_q      <= CW'(1);
      p_q      <= CW'(1);
      mode_q   <= 1'b0;
      mask_q   <= '0;
      pend_q   <= 1'b0;
      ras_n_o  <= '1;
      active_o <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      mask_q   <= mask_d;
      ras_n_o  <= (st_d == ST_RAS) ? ~mask_d : '1;
      active_o <= (st_d != ST_IDLE);
      if (start) begin
        n_q    <= n_in;
        p_q    <= p_in;
        mode_q <= bank_mode_i;
      end
      if (timer_clr_i)          pend_q <= 1'b0;
      else if (int_req_i)       pend_q <= 1'b1;
      else if (start && int_go) pend_q <= 1'b0;
    end
  end

  AST_RAS_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    !(&ras_n_o) |-> active_o); // R11
  AST_STRETCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RAS && cnt_q >= n_q && !mode_q && stretch_i) |=> (ras_n_o == '0)); // R3
  AST_END_ON_LOW: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RAS && cnt_q >= n_q && !stretch_i) |=> (&ras_n_o)); // R3
  AST_BANK_NO_STRETCH: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RAS && cnt_q >= n_q && mode_q) |=> (&ras_n_o)); // R4
  AST_NO_EARLY_START: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PRE && cnt_q < p_q) |=> (&ras_n_o)); // R5
  AST_PEND_HELD: assert property (@(posedge clk) disable iff (rst)
    (pend_q && refresh_inhibit_i && !timer_clr_i) |=> pend_q); // R9
endmodule

// File: rtl/refresh_seq.sv
module refresh_seq #(
  parameter int CLK_HZ  = 100_000_000,
  parameter int ROWS    = 512,
  parameter int NUM_RAS = 4,
  parameter int CW      = 4,
  parameter int AW      = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               refresh_req_i,
  input  logic               refresh_inhibit_i,
  input  logic               stretch_i,
  input  logic               bank_mode_i,
  input  logic [CW-1:0]      ras_cycles_i,
  input  logic [CW-1:0]      pre_cycles_i,
  output logic [NUM_RAS-1:0] ras_n_o,
  output logic [AW-1:0]      row_o,
  output logic               active_o
);
  localparam int TICK_HZ   = 2_000_000;
  localparam int TICK_NS   = 500;
  localparam int REQ_NS    = 15_000;
  localparam int TICK_DIV  = CLK_HZ / TICK_HZ;
  localparam int REQ_TICKS = REQ_NS / TICK_NS;
  localparam int BW        = (NUM_RAS > 1) ? $clog2(NUM_RAS) : 1;

  logic clear_hold, int_req, timer_clr, done;

  assign clear_hold = refresh_req_i && !refresh_inhibit_i;

  rfs_timer #(.TICK_DIV(TICK_DIV), .REQ_TICKS(REQ_TICKS)) u_timer (
    .clk(clk), .rst(rst), .hold_i(clear_hold),
    .req_o(int_req), .clr_o(timer_clr)
  );

  rfs_row_ctr #(.ROWS(ROWS), .AW(AW)) u_row (
    .clk(clk), .rst(rst), .clr_i(clear_hold), .inc_i(done), .row_o(row_o)
  );

  rfs_fsm #(.NUM_RAS(NUM_RAS), .CW(CW), .BW(BW)) u_fsm (
    .clk(clk), .rst(rst),
    .int_req_i(int_req), .timer_clr_i(timer_clr),
    .refresh_req_i(refresh_req_i), .refresh_inhibit_i(refresh_inhibit_i),
    .stretch_i(stretch_i), .bank_mode_i(bank_mode_i),
    .ras_cycles_i(ras_cycles_i), .pre_cycles_i(pre_cycles_i),
    .bank_i(row_o[BW-1:0]),
    .ras_n_o(ras_n_o), .active_o(active_o), .done_o(done)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (&ras_n_o && !active_o && row_o == '0)); // R1
endmodule

// File: tb/refresh_seq_tb.sv
module refresh_seq_tb;
  localparam int CLK_HZ = 100_000_000;
  localparam int ROWS   = 8;
  localparam int NR     = 4;
  localparam int CW     = 4;
  localparam int AW     = 3;
  localparam int TDIV   = CLK_HZ / 2_000_000;
  localparam int PERIOD = TDIV * 30;
  // nibbles: ras cycles, precharge, stretch-high clocks, bank mode
  localparam logic [15:0] VEC [0:11] = '{
    16'h2100, 16'h2110, 16'h2120, 16'h2150, 16'h1100, 16'h1110,
    16'h4330, 16'h4340, 16'h3261, 16'h1231, 16'h0000, 16'h5401 };

  logic clk = 0, rst = 1;
  logic rfsh = 0, inh = 1, ext = 0, mode = 0;
  logic [CW-1:0] rc = 4'd2, pc = 4'd1;
  logic [NR-1:0] ras_n;
  logic [AW-1:0] row;
  logic act;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  refresh_seq #(.CLK_HZ(CLK_HZ), .ROWS(ROWS), .NUM_RAS(NR), .CW(CW), .AW(AW)) u_dut (
    .clk(clk), .rst(rst), .refresh_req_i(rfsh), .refresh_inhibit_i(inh),
    .stretch_i(ext), .bank_mode_i(mode), .ras_cycles_i(rc), .pre_cycles_i(pc),
    .ras_n_o(ras_n), .row_o(row), .active_o(act));

  task automatic chk(input string tag, input int actual, input int expect_v);
    checks++;
    if (actual != expect_v) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expect_v);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int exp_row = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 ras idle", int'(ras_n), 15);
    chk("R1 active", int'(act), 0);
    chk("R1 row", int'(row), 0);

    // table walk: one refresh per vector, inhibit high
    for (int i = 0; i < 12; i++) begin
      int n, p, k, m, ne, pe, low, acnt, j, msk, exl;
      n = VEC[i][15:12]; p = VEC[i][11:8]; k = VEC[i][7:4]; m = VEC[i][0];
      ne = (n == 0) ? 1 : n;
      pe = (p == 0) ? 1 : p;
      @(negedge clk);
      rc = CW'(n); pc = CW'(p); mode = m[0]; rfsh = 1;
      @(negedge clk);
      rfsh = 0;
      low = 0; acnt = 0; j = 0; msk = -1;
      while (act && acnt < 100) begin
        if (ras_n != 4'hF) begin
          low++;
          if (low == 1) msk = int'(ras_n);
        end
        acnt++;
        ext = (j < k);
        j++;
        @(negedge clk);
      end
      ext = 0;
      exl = (m == 0 && k >= ne) ? k + 1 : ne;
      chk((m == 0) ? "R2/R3 low clocks" : "R4 low clocks", low, exl);
      chk("R5/R11 active clocks", acnt, exl + pe);
      chk((m == 0) ? "R2 mask" : "R4 mask", msk,
          (m == 0) ? 0 : int'(~(4'b0001 << (exp_row % NR)) & 4'hF));
      exp_row = (exp_row + 1) % ROWS;
      chk("R6 row step", int'(row), exp_row);
    end

    // held request released by dropping inhibit
    begin
      int bad = 0;
      rc = 4'd3; pc = 4'd2; mode = 0;
      repeat (1600) begin
        @(negedge clk);
        if (ras_n != 4'hF) bad++;
      end
      chk("R9 inhibit holds off", bad, 0);
      inh = 0;
      @(negedge clk);
      chk("R9 held request starts", int'(ras_n), 0);
      while (act) @(negedge clk);
      exp_row = (exp_row + 1) % ROWS;
      chk("R6 row after held", int'(row), exp_row);
    end

    // burst from cleared row, wrap past ROWS
    begin
      int nref = 0, hi = 0, badgap = 0, guard = 0;
      logic prev = 0, lowv;
      @(negedge clk);
      rfsh = 1; inh = 0;
      @(negedge clk);
      inh = 1;
      while ((nref < 10 || act) && guard < 1000) begin
        @(negedge clk);
        guard++;
        lowv = (ras_n != 4'hF);
        if (lowv && !prev) begin
          nref++;
          if (nref > 1 && hi != 2) badgap++;
          hi = 0;
          if (nref == 10) rfsh = 0;
        end
        if (!lowv) hi++;
        prev = lowv;
      end
      chk("R8 burst gaps", badgap, 0);
      chk("R8 burst count", nref, 10);
      repeat (10) @(negedge clk);
      chk("R8 no extra refresh", int'(ras_n), 15);
      chk("R6 wrap after burst", int'(row), 10 % ROWS);
    end

    // clear row, then long hold clears timer
    begin
      int cnt = 0, sp = 0;
      logic seen_hi = 0;
      inh = 0; rfsh = 1;
      @(negedge clk);
      chk("R7 row cleared", int'(row), 0);
      repeat (TDIV + 10) @(negedge clk);
      rfsh = 0;
      while (ras_n == 4'hF && cnt < 5000) begin
        @(negedge clk);
        cnt++;
      end
      chk("R10 first request after timer clear", cnt, PERIOD + 1);
      while (!(seen_hi && ras_n != 4'hF) && sp < 5000) begin
        @(negedge clk);
        sp++;
        if (ras_n == 4'hF) seen_hi = 1;
        if (sp == 700) rfsh = 1;
        if (sp == 710) rfsh = 0;
      end
      chk("R9/R10 period unchanged by short hold", sp, PERIOD);
      while (act) @(negedge clk);
      chk("R7 short hold cleared row", int'(row), 1);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule